// File: doc/BRIEF.md
# Instruction Length Decoder

This block looks at a window of sixteen raw bytes whose first byte is known to begin an instruction of a variable-length 32-bit instruction set. It works out how long that instruction is. It also reports where each of its parts sits inside the window: the prefix run, the opcode, the addressing byte (ModR/M), the scale-index-base byte (SIB), the displacement and the immediate. A fetch or alignment stage uses the result to find the start of the next instruction and to steer the right bytes to the decoders. The length is not a simple table lookup. It comes from a chain of field decodes, and special codes in the ModR/M and SIB bytes change how many displacement bytes follow.

Windows come in on a valid/ready stream, and results leave on a second valid/ready stream one clock after acceptance. Back-pressure works as follows. The block takes a new window only when its result register is empty, or when that register is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, `in_ready` stays low and every result field holds its value. An instruction with too many prefixes, or one whose computed length exceeds the legal maximum, is returned with `out_bad` set. For such an instruction the length and all field reports are zero.

Top module: `insn_length_unit`

## Requirements
- R1: A window accepted (`in_valid` and `in_ready` high at a clock edge) produces its result with `out_valid` high after that same edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, all result outputs hold. A result drained without a new window being accepted clears `out_valid`. After reset, `out_valid` is low.
- R2: Byte i of the window is `in_bytes[8*i+7:8*i]`. The bytes 0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65, 0x66, 0x67, 0xF0, 0xF2 and 0xF3 count as prefixes when they form a consecutive run from byte 0. `out_pfx_cnt` gives the length of that run, from 0 to 4.
- R3: If bytes 0 to 4 are all prefixes, the result has `out_bad`=1, `out_len`=0, and all presence flags, lengths and offsets at 0.
- R4: An opcode byte 0x0F is an escape. The next byte is the real opcode, `out_two_byte`=1, and `out_opc_off` points at that second byte. Otherwise `out_opc_off` equals the prefix count.
- R5: When a ModR/M byte is present, its mode field (bits 7:6) sets the displacement size. 01 gives 1 byte, 10 gives 4 bytes, and 00 gives none, except for the cases in R7 and R8. 11 is a register form with no SIB and no displacement.
- R6: A SIB byte is present exactly when mode is not 11 and R/M (bits 2:0) equals 4. It sits right after the ModR/M byte.
- R7: Mode 00 with R/M 5 carries a 4-byte displacement and no SIB.
- R8: With a SIB byte and mode 00, a SIB base field (bits 2:0) of 5 adds a 4-byte displacement. With mode 01 or 10, the displacement follows R5 whatever the base.
- R9: Opcode classes for one-byte opcodes:
  - 0x00–0x3F with low three bits 0–3: ModR/M, no immediate.
  - 0x00–0x3F with low bits 4: 1-byte immediate.
  - 0x00–0x3F with low bits 5: operand-size immediate.
  - 0x00–0x3F with low bits 6 or 7: neither.
  - 0x80, 0x83, 0xC6: ModR/M plus a 1-byte immediate.
  - 0x81, 0xC7: ModR/M plus an operand-size immediate.
  - 0x84–0x8B and 0x8D: ModR/M only.
  - 0xB0–0xB7: 1-byte immediate.
  - 0xB8–0xBF: operand-size immediate.
  - Any other one-byte opcode: neither.

  Two-byte opcodes 0x80–0x8F carry an operand-size immediate and no ModR/M. All other two-byte opcodes carry ModR/M and no immediate.
- R10: An operand-size immediate is 4 bytes, or 2 bytes when a 0x66 prefix is in the run. 1-byte immediates are unaffected. The 0x67 prefix is counted but leaves addressing in its 32-bit form.
- R11: The fields follow one another in this order: prefixes, opcode, ModR/M, SIB, displacement, immediate. `out_len` is the sum of all field sizes. The offset of a field that is absent reads 0.
- R12: A computed length above `MAX_LEN` (default 15) gives `out_bad`=1, with the length and all field reports at 0. A length of exactly `MAX_LEN` is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Window on `in_bytes` is valid |
| in_ready | output | 1 | Block can accept a window this cycle |
| in_bytes | input | 128 | Raw window, byte 0 in bits 7:0 |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_len | output | 5 | Instruction length in bytes |
| out_bad | output | 1 | Too many prefixes or over-length |
| out_pfx_cnt | output | 3 | Number of prefix bytes |
| out_opc_off | output | 4 | Offset of the operative opcode byte |
| out_two_byte | output | 1 | Escape opcode seen |
| out_has_modrm | output | 1 | ModR/M byte present |
| out_modrm_off | output | 4 | Offset of ModR/M byte |
| out_has_sib | output | 1 | SIB byte present |
| out_sib_off | output | 4 | Offset of SIB byte |
| out_disp_len | output | 3 | Displacement size in bytes |
| out_disp_off | output | 4 | Offset of the first displacement byte |
| out_imm_len | output | 3 | Immediate size in bytes |
| out_imm_off | output | 4 | Offset of the first immediate byte |

## Verification
The bench aims at the escape codes, because a decoder that gets them wrong is off by four bytes. If it ignores mode 00 with R/M 5, it reports a 2-byte instruction where there are 6. If it misses SIB base 5, or applies that rule under mode 01, the next instruction start lands in the middle of a displacement. A window of five prefixes and a 15-byte maximum instruction probe the prefix limit. A second instance with a smaller length limit shows that an 11-byte form is flagged there. A 0x66 prefix is tested on both an operand-size immediate and an 8-bit immediate, since a design that shrinks the wrong one misplaces every following byte. A stalled consumer checks that results are neither overwritten nor dropped.

// File: rtl/ilen_pkg.sv
package ilen_pkg;

  typedef enum logic [1:0] {
    IMMK_NONE = 2'd0,
    IMMK_BYTE = 2'd1,
    IMMK_OPSZ = 2'd2
  } imm_kind_e;

  localparam int DISP_SHORT = 1;
  localparam int DISP_WIDE  = 4;
  localparam int IMM_NARROW = 2;
  localparam int IMM_WIDE   = 4;

  localparam logic [7:0] ESCAPE_BYTE = 8'h0F;
  localparam logic [7:0] OPSIZE_BYTE = 8'h66;

  function automatic logic is_legacy_prefix(input logic [7:0] b);
    case (b)
      8'h26, 8'h2E, 8'h36, 8'h3E,
      8'h64, 8'h65, 8'h66, 8'h67,
      8'hF0, 8'hF2, 8'hF3: is_legacy_prefix = 1'b1;
      default:             is_legacy_prefix = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ilen_prefix_scan.sv
module ilen_prefix_scan #(
  parameter int MAX_PFX = 4,
  localparam int SCAN  = MAX_PFX + 1,
  localparam int CNT_W = $clog2(MAX_PFX + 2)
) (
  input  logic [8*SCAN-1:0] win,
  output logic [CNT_W-1:0]  pfx_cnt,
  output logic              pfx_overflow,
  output logic              opsz_ovr
);

  logic [SCAN-1:0] is_pfx;
  logic [SCAN-1:0] is_opsz;

  for (genvar g = 0; g < SCAN; g++) begin : g_pos
    assign is_pfx[g]  = ilen_pkg::is_legacy_prefix(win[8*g +: 8]);
    assign is_opsz[g] = (win[8*g +: 8] == ilen_pkg::OPSIZE_BYTE);
  end

  always_comb begin
    logic run;
    run      = 1'b1;
    pfx_cnt  = '0;
    opsz_ovr = 1'b0;
    for (int i = 0; i < SCAN; i++) begin
      if (run && is_pfx[i]) begin
        pfx_cnt = pfx_cnt + 1'b1;
        if (is_opsz[i]) opsz_ovr = 1'b1;
      end else begin
        run = 1'b0;
      end
    end
    pfx_overflow = (pfx_cnt == CNT_W'(SCAN));
  end

endmodule

// File: rtl/ilen_opcode_class.sv
module ilen_opcode_class (
  input  logic                  two_byte,
  input  logic [7:0]            opc,
  output logic                  has_modrm,
  output ilen_pkg::imm_kind_e   imm_kind
);
  import ilen_pkg::*;

  always_comb begin
    has_modrm = 1'b0;
    imm_kind  = IMMK_NONE;
    if (two_byte) begin
      if (opc[7:4] == 4'h8) imm_kind = IMMK_OPSZ;
      else                  has_modrm = 1'b1;
    end else if (opc[7:6] == 2'b00) begin
      case (opc[2:0])
        3'd0, 3'd1, 3'd2, 3'd3: has_modrm = 1'b1;
        3'd4:                   imm_kind  = IMMK_BYTE;
        3'd5:                   imm_kind  = IMMK_OPSZ;
        default:                ;
      endcase
    end else begin
      case (opc) inside
        8'h80, 8'h83, 8'hC6: begin
          has_modrm = 1'b1;
          imm_kind  = IMMK_BYTE;
        end
        8'h81, 8'hC7: begin
          has_modrm = 1'b1;
          imm_kind  = IMMK_OPSZ;
        end
        [8'h84:8'h8B], 8'h8D: has_modrm = 1'b1;
        [8'hB0:8'hB7]:        imm_kind  = IMMK_BYTE;
        [8'hB8:8'hBF]:        imm_kind  = IMMK_OPSZ;
        default:              ;
      endcase
    end
  end

endmodule

// File: rtl/ilen_modrm_size.sv
module ilen_modrm_size #(
  parameter int FLD_W = 3
) (
  input  logic             present,
  input  logic [1:0]       mode,
  input  logic [2:0]       rm,
  input  logic [2:0]       sib_base,
  output logic             has_sib,
  output logic [FLD_W-1:0] disp_len
);
  import ilen_pkg::*;

  assign has_sib = present && (mode != 2'b11) && (rm == 3'd4);

  always_comb begin
    disp_len = '0;
    if (present) begin
      case (mode)
        2'b01: disp_len = FLD_W'(DISP_SHORT);
        2'b10: disp_len = FLD_W'(DISP_WIDE);
        2'b00: begin
          if (rm == 3'd5)                    disp_len = FLD_W'(DISP_WIDE);
          else if (has_sib && sib_base == 3'd5) disp_len = FLD_W'(DISP_WIDE);
        end
        default: disp_len = '0;
      endcase
    end
  end

endmodule

// File: rtl/insn_length_unit.sv
module insn_length_unit #(
  parameter int WIN_BYTES = 16,
  parameter int MAX_PFX   = 4,
  parameter int MAX_LEN   = 15,
  localparam int OFF_W = $clog2(WIN_BYTES),
  localparam int LEN_W = OFF_W + 1,
  localparam int CNT_W = $clog2(MAX_PFX + 2),
  localparam int FLD_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [8*WIN_BYTES-1:0] in_bytes,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LEN_W-1:0]       out_len,
  output logic                   out_bad,
  output logic [CNT_W-1:0]       out_pfx_cnt,
  output logic [OFF_W-1:0]       out_opc_off,
  output logic                   out_two_byte,
  output logic                   out_has_modrm,
  output logic [OFF_W-1:0]       out_modrm_off,
  output logic                   out_has_sib,
  output logic [OFF_W-1:0]       out_sib_off,
  output logic [FLD_W-1:0]       out_disp_len,
  output logic [OFF_W-1:0]       out_disp_off,
  output logic [FLD_W-1:0]       out_imm_len,
  output logic [OFF_W-1:0]       out_imm_off
);
  import ilen_pkg::*;

  localparam int SCAN = MAX_PFX + 1;

  logic [7:0] wb [WIN_BYTES];
  for (genvar g = 0; g < WIN_BYTES; g++) begin : g_bytes
    assign wb[g] = in_bytes[8*g +: 8];
  end

  // stage 1: prefix run
  logic [CNT_W-1:0] pfx_cnt_c;
  logic             pfx_over;
  logic             opsz;

  ilen_prefix_scan #(.MAX_PFX(MAX_PFX)) u_scan (
    .win          (in_bytes[8*SCAN-1:0]),
    .pfx_cnt      (pfx_cnt_c),
    .pfx_overflow (pfx_over),
    .opsz_ovr     (opsz)
  );

  // stage 2: opcode position and class
  logic [LEN_W-1:0] p_first, p_opc, p_modrm, p_disp, p_imm, len_c;
  logic             esc;
  logic [7:0]       opc_byte;
  logic             has_modrm;
  imm_kind_e        imm_kind;

  assign p_first  = pfx_over ? '0 : LEN_W'(pfx_cnt_c);
  assign esc      = (wb[p_first[OFF_W-1:0]] == ESCAPE_BYTE);
  assign p_opc    = p_first + LEN_W'(esc);
  assign opc_byte = wb[p_opc[OFF_W-1:0]];
  assign p_modrm  = p_opc + LEN_W'(1);

  ilen_opcode_class u_class (
    .two_byte  (esc),
    .opc       (opc_byte),
    .has_modrm (has_modrm),
    .imm_kind  (imm_kind)
  );

  // stage 3: addressing bytes
  logic [7:0]       modrm_b, sib_b;
  logic             has_sib;
  logic [FLD_W-1:0] disp_len;
  logic [OFF_W-1:0] sib_idx;

  assign modrm_b = wb[p_modrm[OFF_W-1:0]];
  assign sib_idx = OFF_W'(p_modrm + LEN_W'(1));
  assign sib_b   = wb[sib_idx];

  ilen_modrm_size #(.FLD_W(FLD_W)) u_addr (
    .present  (has_modrm),
    .mode     (modrm_b[7:6]),
    .rm       (modrm_b[2:0]),
    .sib_base (sib_b[2:0]),
    .has_sib  (has_sib),
    .disp_len (disp_len)
  );

  // stage 4: immediate and total length
  logic [FLD_W-1:0] imm_len;
  logic [LEN_W-1:0] addr_bytes;
  logic             len_over, bad_c;

  always_comb begin
    case (imm_kind)
      IMMK_BYTE: imm_len = FLD_W'(1);
      IMMK_OPSZ: imm_len = opsz ? FLD_W'(IMM_NARROW) : FLD_W'(IMM_WIDE);
      default:   imm_len = '0;
    endcase
  end

  assign addr_bytes = has_modrm ? (has_sib ? LEN_W'(2) : LEN_W'(1)) : '0;
  assign p_disp     = p_modrm + addr_bytes;
  assign p_imm      = p_disp + LEN_W'(disp_len);
  assign len_c      = p_imm + LEN_W'(imm_len);
  assign len_over   = (len_c > LEN_W'(MAX_LEN));
  assign bad_c      = pfx_over || len_over;

  // result register with stream handshake
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_len       <= '0;
      out_bad       <= 1'b0;
      out_pfx_cnt   <= '0;
      out_opc_off   <= '0;
      out_two_byte  <= 1'b0;
      out_has_modrm <= 1'b0;
      out_modrm_off <= '0;
      out_has_sib   <= 1'b0;
      out_sib_off   <= '0;
      out_disp_len  <= '0;
      out_disp_off  <= '0;
      out_imm_len   <= '0;
      out_imm_off   <= '0;
    end else if (take) begin
      out_valid     <= 1'b1;
      out_bad       <= bad_c;
      out_len       <= bad_c ? '0 : len_c;
      out_pfx_cnt   <= bad_c ? '0 : pfx_cnt_c;
      out_opc_off   <= bad_c ? '0 : p_opc[OFF_W-1:0];
      out_two_byte  <= !bad_c && esc;
      out_has_modrm <= !bad_c && has_modrm;
      out_modrm_off <= (!bad_c && has_modrm) ? p_modrm[OFF_W-1:0] : '0;
      out_has_sib   <= !bad_c && has_sib;
      out_sib_off   <= (!bad_c && has_sib) ? sib_idx : '0;
      out_disp_len  <= bad_c ? '0 : disp_len;
      out_disp_off  <= (!bad_c && disp_len != '0) ? p_disp[OFF_W-1:0] : '0;
      out_imm_len   <= bad_c ? '0 : imm_len;
      out_imm_off   <= (!bad_c && imm_len != '0) ? p_imm[OFF_W-1:0] : '0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/ilen_checker.sv
module ilen_checker #(
  parameter int WIN_BYTES = 16,
  parameter int MAX_PFX   = 4,
  parameter int MAX_LEN   = 15,
  localparam int OFF_W = $clog2(WIN_BYTES),
  localparam int LEN_W = OFF_W + 1,
  localparam int CNT_W = $clog2(MAX_PFX + 2),
  localparam int FLD_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [LEN_W-1:0] out_len,
  input logic             out_bad,
  input logic [CNT_W-1:0] out_pfx_cnt,
  input logic             out_has_modrm,
  input logic [OFF_W-1:0] out_modrm_off,
  input logic             out_has_sib,
  input logic [OFF_W-1:0] out_sib_off,
  input logic [FLD_W-1:0] out_disp_len,
  input logic [FLD_W-1:0] out_imm_len,
  input logic [OFF_W-1:0] out_imm_off
);

  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R1

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_len) && $stable(out_bad)); // R1

  AST_PFX_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_bad |-> out_pfx_cnt <= CNT_W'(MAX_PFX)); // R2

  AST_BAD_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_bad |-> out_len == '0 && !out_has_modrm && !out_has_sib && out_imm_len == '0); // R3

  AST_DISP_SIZES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_disp_len == 3'd0 || out_disp_len == 3'd1 || out_disp_len == 3'd4); // R5

  AST_SIB_AFTER_MODRM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_has_sib |-> out_has_modrm && ({1'b0, out_sib_off} == {1'b0, out_modrm_off} + LEN_W'(1))); // R6

  AST_IMM_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_bad && out_imm_len != '0 |-> out_len == {1'b0, out_imm_off} + LEN_W'(out_imm_len)); // R11

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_bad |-> out_len >= LEN_W'(1) && out_len <= LEN_W'(MAX_LEN)); // R12

endmodule

bind insn_length_unit ilen_checker #(
  .WIN_BYTES (WIN_BYTES),
  .MAX_PFX   (MAX_PFX),
  .MAX_LEN   (MAX_LEN)
) u_ilen_checker (.*);

// File: tb/test_insn_length_unit.sv
module test_insn_length_unit;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         out_ready = 1'b1;
  logic [127:0] in_bytes = '0;

  logic       in_ready, out_valid, out_bad, out_two_byte, out_has_modrm, out_has_sib;
  logic [4:0] out_len;
  logic [2:0] out_pfx_cnt, out_disp_len, out_imm_len;
  logic [3:0] out_opc_off, out_modrm_off, out_sib_off, out_disp_off, out_imm_off;

  logic       l_in_ready, l_out_valid, l_out_bad, l_two_byte, l_has_modrm, l_has_sib;
  logic [4:0] l_len;
  logic [2:0] l_pfx_cnt, l_disp_len, l_imm_len;
  logic [3:0] l_opc_off, l_modrm_off, l_sib_off, l_disp_off, l_imm_off;

  int  checks = 0;
  int  errs   = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  insn_length_unit i_insn_length_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bytes(in_bytes), .out_valid(out_valid), .out_ready(out_ready),
    .out_len(out_len), .out_bad(out_bad), .out_pfx_cnt(out_pfx_cnt),
    .out_opc_off(out_opc_off), .out_two_byte(out_two_byte),
    .out_has_modrm(out_has_modrm), .out_modrm_off(out_modrm_off),
    .out_has_sib(out_has_sib), .out_sib_off(out_sib_off),
    .out_disp_len(out_disp_len), .out_disp_off(out_disp_off),
    .out_imm_len(out_imm_len), .out_imm_off(out_imm_off)
  );

  insn_length_unit #(.MAX_LEN(10)) i_insn_length_unit_lim (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(l_in_ready),
    .in_bytes(in_bytes), .out_valid(l_out_valid), .out_ready(1'b1),
    .out_len(l_len), .out_bad(l_out_bad), .out_pfx_cnt(l_pfx_cnt),
    .out_opc_off(l_opc_off), .out_two_byte(l_two_byte),
    .out_has_modrm(l_has_modrm), .out_modrm_off(l_modrm_off),
    .out_has_sib(l_has_sib), .out_sib_off(l_sib_off),
    .out_disp_len(l_disp_len), .out_disp_off(l_disp_off),
    .out_imm_len(l_imm_len), .out_imm_off(l_imm_off)
  );

  // literal is written with byte 0 leftmost
  function automatic logic [127:0] order(input logic [127:0] be);
    for (int i = 0; i < 16; i++) order[8*i +: 8] = be[127-8*i -: 8];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_case(input string tag, input logic [127:0] be,
                          input int e_len, input int e_bad, input int e_pfx,
                          input int e_opc, input int e_two, input int e_mrm,
                          input int e_sib, input int e_dlen, input int e_doff,
                          input int e_ilen, input int e_ioff);
    @(negedge clk);
    in_bytes  = order(be);
    in_valid  = 1'b1;
    out_ready = 1'b1;
    chk({tag, " R1 in_ready"}, int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R1 out_valid"}, int'(out_valid), 1);
    chk({tag, " len"},       int'(out_len), e_len);
    chk({tag, " bad"},       int'(out_bad), e_bad);
    chk({tag, " pfx_cnt"},   int'(out_pfx_cnt), e_pfx);
    chk({tag, " opc_off"},   int'(out_opc_off), e_opc);
    chk({tag, " two_byte"},  int'(out_two_byte), e_two);
    chk({tag, " has_modrm"}, int'(out_has_modrm), int'(e_mrm != 0));
    chk({tag, " modrm_off"}, int'(out_modrm_off), e_mrm);
    chk({tag, " has_sib"},   int'(out_has_sib), int'(e_sib != 0));
    chk({tag, " sib_off"},   int'(out_sib_off), e_sib);
    chk({tag, " disp_len"},  int'(out_disp_len), e_dlen);
    chk({tag, " disp_off"},  int'(out_disp_off), e_doff);
    chk({tag, " imm_len"},   int'(out_imm_len), e_ilen);
    chk({tag, " imm_off"},   int'(out_imm_off), e_ioff);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset in_ready", int'(in_ready), 1);
    chk("R1 idle out_valid", int'(out_valid), 0);
  endtask

  task automatic t_basic_forms();
    run_case("R11 single byte",   128'h90_00_00_00_00_00_00_00_00_00_00_00_00_00_00_00, 1,0,0,0,0, 0,0,0,0,0,0);
    run_case("R5 mode11 reg",     128'h01_D9_00_00_00_00_00_00_00_00_00_00_00_00_00_00, 2,0,0,0,0, 1,0,0,0,0,0);
    run_case("R6 mode11 rm4",     128'h01_E4_00_00_00_00_00_00_00_00_00_00_00_00_00_00, 2,0,0,0,0, 1,0,0,0,0,0);
    run_case("R5 mode01 disp8",   128'h03_45_08_00_00_00_00_00_00_00_00_00_00_00_00_00, 3,0,0,0,0, 1,0,1,2,0,0);
  endtask

  task automatic t_escape_codes();
    run_case("R7 mode00 rm5",     128'h03_05_78_56_34_12_00_00_00_00_00_00_00_00_00_00, 6,0,0,0,0, 1,0,4,2,0,0);
    run_case("R6 sib base4",      128'h03_04_24_00_00_00_00_00_00_00_00_00_00_00_00_00, 3,0,0,0,0, 1,2,0,0,0,0);
    run_case("R8 sib base5 mode00", 128'h03_04_25_78_56_34_12_00_00_00_00_00_00_00_00_00, 7,0,0,0,0, 1,2,4,3,0,0);
    run_case("R8 sib base5 mode01", 128'h03_44_25_08_00_00_00_00_00_00_00_00_00_00_00_00, 4,0,0,0,0, 1,2,1,3,0,0);
  endtask

  task automatic t_immediates();
    run_case("R9 C7 sib disp32 imm32", 128'hC7_84_C3_11_22_33_44_78_56_34_12_00_00_00_00_00, 11,0,0,0,0, 1,2,4,3,4,7);
    run_case("R10 66 C7 imm16",   128'h66_C7_84_C3_11_22_33_44_34_12_00_00_00_00_00_00, 10,0,1,1,0, 2,3,4,4,2,8);
    run_case("R9 alu AL imm8",    128'h04_7F_00_00_00_00_00_00_00_00_00_00_00_00_00_00, 2,0,0,0,0, 0,0,0,0,1,1);
    run_case("R9 alu eAX imm32",  128'h05_78_56_34_12_00_00_00_00_00_00_00_00_00_00_00, 5,0,0,0,0, 0,0,0,0,4,1);
    run_case("R10 66 alu eAX",    128'h66_05_34_12_00_00_00_00_00_00_00_00_00_00_00_00, 4,0,1,1,0, 0,0,0,0,2,2);
    run_case("R9 B0 imm8",        128'hB0_12_00_00_00_00_00_00_00_00_00_00_00_00_00_00, 2,0,0,0,0, 0,0,0,0,1,1);
    run_case("R9 B8 imm32",       128'hB8_78_56_34_12_00_00_00_00_00_00_00_00_00_00_00, 5,0,0,0,0, 0,0,0,0,4,1);
    run_case("R10 66 B8 imm16",   128'h66_B8_34_12_00_00_00_00_00_00_00_00_00_00_00_00, 4,0,1,1,0, 0,0,0,0,2,2);
    run_case("R9 83 modrm imm8",  128'h83_C0_01_00_00_00_00_00_00_00_00_00_00_00_00_00, 3,0,0,0,0, 1,0,0,0,1,2);
    run_case("R10 66 83 imm8 kept", 128'h66_83_C0_01_00_00_00_00_00_00_00_00_00_00_00_00, 4,0,1,1,0, 2,0,0,0,1,3);
  endtask

  task automatic t_two_byte();
    run_case("R4 escape modrm",   128'h0F_AF_C1_00_00_00_00_00_00_00_00_00_00_00_00_00, 3,0,0,1,1, 2,0,0,0,0,0);
    run_case("R4 escape rel32",   128'h0F_84_78_56_34_12_00_00_00_00_00_00_00_00_00_00, 6,0,0,1,1, 0,0,0,0,4,2);
  endtask

  task automatic t_prefixes();
    run_case("R2 four prefixes",  128'hF0_F2_66_67_90_00_00_00_00_00_00_00_00_00_00_00, 5,0,4,4,0, 0,0,0,0,0,0);
    run_case("R10 67 keeps 32bit", 128'h67_03_45_08_00_00_00_00_00_00_00_00_00_00_00_00, 4,0,1,1,0, 2,0,1,3,0,0);
    run_case("R3 five prefixes",  128'h26_2E_36_3E_64_90_00_00_00_00_00_00_00_00_00_00, 0,1,0,0,0, 0,0,0,0,0,0);
    run_case("R12 max length 15", 128'h26_2E_36_3E_C7_84_C3_11_22_33_44_78_56_34_12_00, 15,0,4,4,0, 5,6,4,7,4,11);
  endtask

  task automatic t_limit();
    // second instance has a limit of 10 bytes
    @(negedge clk);
    in_bytes = order(128'hC7_84_C3_11_22_33_44_78_56_34_12_00_00_00_00_00);
    in_valid = 1'b1;
    @(negedge clk);
    chk("R12 lim 11B valid", int'(l_out_valid), 1);
    chk("R12 lim 11B bad",   int'(l_out_bad), 1);
    chk("R12 lim 11B len",   int'(l_len), 0);
    chk("R12 lim 11B imm",   int'(l_imm_len), 0);
    in_bytes = order(128'h66_C7_84_C3_11_22_33_44_34_12_00_00_00_00_00_00);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R12 lim 10B bad",   int'(l_out_bad), 0);
    chk("R12 lim 10B len",   int'(l_len), 10);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    in_bytes  = order(128'h90_00_00_00_00_00_00_00_00_00_00_00_00_00_00_00);
    in_valid  = 1'b1;
    @(negedge clk);
    in_bytes = order(128'hB8_78_56_34_12_00_00_00_00_00_00_00_00_00_00_00);
    chk("R1 stall in_ready", int'(in_ready), 0);
    chk("R1 stall len A",    int'(out_len), 1);
    @(negedge clk);
    chk("R1 stall valid",    int'(out_valid), 1);
    chk("R1 stall held A",   int'(out_len), 1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 drain+load B valid", int'(out_valid), 1);
    chk("R1 drain+load B len",   int'(out_len), 5);
    @(negedge clk);
    chk("R1 drained clears", int'(out_valid), 0);
  endtask

  initial begin
    t_reset();
    t_basic_forms();
    t_escape_codes();
    t_immediates();
    t_two_byte();
    t_prefixes();
    t_limit();
    t_backpressure();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule